// File: doc/BRIEF.md
# Flat page-table address translator

This block turns client virtual addresses into physical addresses by way of one flat table of 32-bit page entries kept in memory. The translated window starts at the fixed virtual address 0x0100_0000 and is a programmable number of 64 KB regions long. Each 4 KB page of the window owns one entry in the table, so the table is a plain array: the entry for a page lies at the table base plus four times the page index. The page index is the virtual address minus 0x0100_0000, divided by 4096.

A small fully-associative cache keeps the most recently fetched entries. On a miss the block issues a single read on its memory port and holds the requester until the data returns. Every access is checked for window membership, for a non-empty entry, for the needed read or write permission, and for a physical page inside a programmable protection window. A failing access is answered with a fault flag and the programmed error-redirect address. The first faulting virtual address is also held in a sticky status output. An invalidate strobe empties the cache.

A requester raises `req_valid` with the address and the read/write flag, and holds them until `rsp_valid` pulses. It must drop or change the request on the clock edge that ends the response cycle.

Top module: `flat_xlate`

## Requirements
- R1: After reset `rsp_valid`, `mem_rd_req` and `flt_valid` are low.
- R2: A virtual address below 0x0100_0000, or at or above 0x0100_0000 + `cfg_regions` × 0x1_0000, is answered with a fault and causes no table read.
- R3: A cache miss issues exactly one one-cycle `mem_rd_req` at address `cfg_tbl_base` + 4 × ((va − 0x0100_0000) >> 12). The response is a one-cycle `rsp_valid` pulse that comes after `mem_rd_ack`.
- R4: A permitted access answers `rsp_fault`=0 with `rsp_addr` = {entry[31:12], va[11:0]}.
- R5: An entry of all zeros faults. A write needs entry bit 0 set and a read needs entry bit 1 set; otherwise the access faults.
- R6: If the physical page address {entry[31:12], 12'h000} is below `cfg_win_lo` or above `cfg_win_hi`, the access faults.
- R7: Every fault answers `rsp_fault`=1 with `rsp_addr` = `cfg_err_addr`.
- R8: The first fault sets `flt_valid` and stores its virtual address in `flt_vaddr`. Both hold through later faults until `flt_clr`. When a clear and a new fault meet in one cycle, the new fault is recorded.
- R9: The cache holds 4 entries with round-robin replacement. A repeated access to a cached page issues no read. After misses on five distinct pages, the first of them is the only one evicted.
- R10: `inval` drops every cached entry. The next access to any page reads its entry again and uses the new memory contents.
- R11: When `inval` is seen while a table read is outstanding, that read still answers its request, but its entry is not cached. The next access to the same page reads again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tbl_base | input | 32 | Byte address of table entry 0 |
| cfg_regions | input | 12 | Window length in 64 KB regions |
| cfg_err_addr | input | 32 | Redirect address for faults (32-byte aligned) |
| cfg_win_lo | input | 32 | Lowest allowed physical page address |
| cfg_win_hi | input | 32 | Highest allowed physical page address |
| inval | input | 1 | Invalidate-all strobe |
| flt_clr | input | 1 | Clears the sticky fault record |
| req_valid | input | 1 | Request present, held until response |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_rd_ack | input | 1 | Table read data valid |
| mem_rd_data | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 32 | Physical address or redirect address |
| rsp_fault | output | 1 | Access faulted |
| mem_rd_req | output | 1 | One-cycle table read strobe |
| mem_rd_addr | output | 32 | Table read byte address |
| flt_valid | output | 1 | Sticky fault recorded |
| flt_vaddr | output | 32 | Virtual address of the recorded fault |

## Verification
The hardest case to reach from the ports is an invalidate that lands while a table read is in flight. The bench's memory model answers three cycles after each read strobe. The request task raises `inval` on the very cycle it sees `mem_rd_req`, so the strobe lands inside that gap. A second access to the same page must then read again. Round-robin eviction is shown through the read count alone: five distinct misses are followed by hits on the four newest pages and one reread of the oldest. Every page of a 16-page window is swept with both access types, using entries that mix all permission codes, empty entries and frames outside the protection window.

// File: rtl/flat_xlate_pkg.sv
package flat_xlate_pkg;
  localparam int unsigned PG_BITS  = 12;
  localparam int unsigned TAG_BITS = 32 - PG_BITS;

  typedef enum logic {S_IDLE, S_WAIT} xl_state_e;

  typedef struct packed {
    logic [TAG_BITS-1:0] frame;
    logic [9:0]          rsvd;
    logic                rd_ok;
    logic                wr_ok;
  } pte_t;
endpackage

// File: rtl/xl_check.sv
module xl_check
  import flat_xlate_pkg::*;
(
  input  logic [PG_BITS-1:0] va_off,
  input  logic               wr,
  input  pte_t               pte,
  input  logic [31:0]        win_lo,
  input  logic [31:0]        win_hi,
  output logic [31:0]        pa,
  output logic               fault
);
  logic [31:0] page;
  logic        perm_bad;

  always_comb begin
    page     = {pte.frame, {PG_BITS{1'b0}}};
    pa       = {pte.frame, va_off};
    perm_bad = wr ? !pte.wr_ok : !pte.rd_ok;
    fault    = (pte == '0) || perm_bad || (page < win_lo) || (page > win_hi);
  end
endmodule

// File: rtl/xl_tlb.sv
module xl_tlb
  import flat_xlate_pkg::*;
#(
  parameter int unsigned NWAY = 4,
  parameter int unsigned TAGW = TAG_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TAGW-1:0] lk_tag,
  output logic            hit,
  output logic [31:0]     hit_pte,
  input  logic            fill_en,
  input  logic [TAGW-1:0] fill_tag,
  input  logic [31:0]     fill_pte,
  input  logic            inval
);
  localparam int unsigned PW = (NWAY > 1) ? $clog2(NWAY) : 1;

  logic [NWAY-1:0] vld_q, vld_n, match;
  logic [TAGW-1:0] tag_q [NWAY];
  logic [31:0]     dat_q [NWAY];
  logic [PW-1:0]   ptr_q, ptr_n;

  for (genvar g = 0; g < NWAY; g++) begin : g_way
    assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    hit     = |match;
    hit_pte = '0;
    for (int i = 0; i < NWAY; i++)
      if (match[i]) hit_pte = hit_pte | dat_q[i];
  end

  always_comb begin
    vld_n = vld_q;
    ptr_n = ptr_q;
    if (inval) begin
      vld_n = '0;
    end else if (fill_en) begin
      vld_n[ptr_q] = 1'b1;
      ptr_n = (ptr_q == PW'(NWAY - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_n;
      ptr_q <= ptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !inval) begin
      tag_q[ptr_q] <= fill_tag;
      dat_q[ptr_q] <= fill_pte;
    end
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R9
  AST_INVAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> (vld_q == '0)); // R10
endmodule

// File: rtl/xl_flog.sv
module xl_flog (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set,
  input  logic [31:0] set_va,
  input  logic        clr,
  output logic        flt_valid,
  output logic [31:0] flt_vaddr
);
  logic        vld_n;
  logic [31:0] va_n;
  logic        load;

  always_comb begin
    load  = set && (clr || !flt_valid);
    vld_n = load ? 1'b1 : (clr ? 1'b0 : flt_valid);
    va_n  = load ? set_va : flt_vaddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_vaddr <= '0;
    end else begin
      flt_valid <= vld_n;
      flt_vaddr <= va_n;
    end
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !clr) |=> (flt_valid && $stable(flt_vaddr))); // R8
endmodule

// File: rtl/flat_xlate.sv
module flat_xlate
  import flat_xlate_pkg::*;
#(
  parameter int unsigned NWAY    = 4,
  parameter int unsigned RGNW    = 12,
  parameter logic [31:0] VA_BASE = 32'h0100_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     cfg_tbl_base,
  input  logic [RGNW-1:0] cfg_regions,
  input  logic [31:0]     cfg_err_addr,
  input  logic [31:0]     cfg_win_lo,
  input  logic [31:0]     cfg_win_hi,
  input  logic            inval,
  input  logic            flt_clr,
  input  logic            req_valid,
  input  logic [31:0]     req_addr,
  input  logic            req_write,
  input  logic            mem_rd_ack,
  input  logic [31:0]     mem_rd_data,
  output logic            rsp_valid,
  output logic [31:0]     rsp_addr,
  output logic            rsp_fault,
  output logic            mem_rd_req,
  output logic [31:0]     mem_rd_addr,
  output logic            flt_valid,
  output logic [31:0]     flt_vaddr
);
  localparam int unsigned RGN_SH = 16;
  localparam int unsigned PADW   = 32 - RGNW - RGN_SH;

  xl_state_e   st_q, st_n;
  logic [31:0] va_q, va_n;
  logic        wr_q, wr_n, kill_q, kill_n;
  logic        rsp_v_n, rsp_f_n, rd_req_n;
  logic [31:0] rsp_a_n, rd_addr_n;

  logic [31:0] va_off, win_size;
  logic        in_rng, accept, waiting;
  logic        hit, fill_en, chk_fault;
  logic [31:0] hit_pte, chk_va, chk_pa;
  logic        chk_wr;
  pte_t        chk_pte;

  always_comb begin
    va_off   = req_addr - VA_BASE;
    win_size = {{PADW{1'b0}}, cfg_regions, {RGN_SH{1'b0}}};
    in_rng   = (req_addr >= VA_BASE) && (va_off < win_size);
    waiting  = (st_q == S_WAIT);
    accept   = !waiting && req_valid && !rsp_valid;
    chk_va   = waiting ? va_q : req_addr;
    chk_wr   = waiting ? wr_q : req_write;
    chk_pte  = waiting ? pte_t'(mem_rd_data) : pte_t'(hit_pte);
  end

  xl_tlb #(.NWAY(NWAY), .TAGW(TAG_BITS)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_tag   (req_addr[31:PG_BITS]),
    .hit      (hit),
    .hit_pte  (hit_pte),
    .fill_en  (fill_en),
    .fill_tag (va_q[31:PG_BITS]),
    .fill_pte (mem_rd_data),
    .inval    (inval)
  );

  xl_check u_chk (
    .va_off (chk_va[PG_BITS-1:0]),
    .wr     (chk_wr),
    .pte    (chk_pte),
    .win_lo (cfg_win_lo),
    .win_hi (cfg_win_hi),
    .pa     (chk_pa),
    .fault  (chk_fault)
  );

  always_comb begin
    st_n      = st_q;
    va_n      = va_q;
    wr_n      = wr_q;
    kill_n    = kill_q;
    rsp_v_n   = 1'b0;
    rsp_f_n   = rsp_fault;
    rsp_a_n   = rsp_addr;
    rd_req_n  = 1'b0;
    rd_addr_n = mem_rd_addr;
    fill_en   = 1'b0;
    if (!waiting) begin
      if (accept) begin
        va_n   = req_addr;
        wr_n   = req_write;
        kill_n = 1'b0;
        if (!in_rng) begin
          rsp_v_n = 1'b1;
          rsp_f_n = 1'b1;
          rsp_a_n = cfg_err_addr;
        end else if (hit) begin
          rsp_v_n = 1'b1;
          rsp_f_n = chk_fault;
          rsp_a_n = chk_fault ? cfg_err_addr : chk_pa;
        end else begin
          rd_req_n  = 1'b1;
          rd_addr_n = cfg_tbl_base + {10'd0, va_off[31:PG_BITS], 2'b00};
          st_n      = S_WAIT;
        end
      end
    end else begin
      kill_n = kill_q || inval;
      if (mem_rd_ack) begin
        rsp_v_n = 1'b1;
        rsp_f_n = chk_fault;
        rsp_a_n = chk_fault ? cfg_err_addr : chk_pa;
        fill_en = !(kill_q || inval);
        st_n    = S_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      kill_q      <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_addr    <= '0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      st_q        <= st_n;
      va_q        <= va_n;
      wr_q        <= wr_n;
      kill_q      <= kill_n;
      rsp_valid   <= rsp_v_n;
      rsp_fault   <= rsp_f_n;
      rsp_addr    <= rsp_a_n;
      mem_rd_req  <= rd_req_n;
      mem_rd_addr <= rd_addr_n;
    end
  end

  xl_flog u_flog (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       (rsp_v_n && rsp_f_n),
    .set_va    (chk_va),
    .clr       (flt_clr),
    .flt_valid (flt_valid),
    .flt_vaddr (flt_vaddr)
  );

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req); // R3
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3
  AST_NO_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && $past(rsp_valid)) |-> 1'b0); // R3
  AST_FAULT_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr == $past(cfg_err_addr))); // R7
  AST_PA_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |->
      (({rsp_addr[31:PG_BITS], 12'h000} >= $past(cfg_win_lo)) &&
       ({rsp_addr[31:PG_BITS], 12'h000} <= $past(cfg_win_hi)))); // R6
endmodule

// File: tb/flat_xlate_test.sv
module flat_xlate_test;
  localparam logic [31:0] BASE = 32'h0000_8000;
  localparam logic [31:0] ERRA = 32'h00AB_C0E0;
  localparam logic [31:0] WLO  = 32'h0010_0000;
  localparam logic [31:0] WHI  = 32'h7FFF_F000;
  localparam logic [31:0] VST  = 32'h0100_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] cfg_regions = 12'd1;
  logic inval_t = 1'b0, flt_clr = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic mem_rd_ack = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic rsp_valid, rsp_fault, mem_rd_req, flt_valid;
  logic [31:0] rsp_addr, mem_rd_addr, flt_vaddr;

  int total = 0, bad = 0;
  int rd_cnt = 0;
  logic [31:0] last_addr = '0;
  logic [31:0] tbl [64];
  logic pend = 1'b0;
  int dly = 0;
  int idx = 0;

  always #10 clk = ~clk;

  flat_xlate uut (
    .clk(clk), .rst_n(rst_n), .cfg_tbl_base(BASE), .cfg_regions(cfg_regions),
    .cfg_err_addr(ERRA), .cfg_win_lo(WLO), .cfg_win_hi(WHI), .inval(inval_t),
    .flt_clr(flt_clr), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .flt_valid(flt_valid), .flt_vaddr(flt_vaddr)
  );

  // memory model: answers three falling edges after a read strobe
  always @(negedge clk) begin
    mem_rd_ack <= 1'b0;
    if (pend) begin
      if (dly == 0) begin
        mem_rd_ack  <= 1'b1;
        mem_rd_data <= tbl[idx];
        pend        <= 1'b0;
      end else dly <= dly - 1;
    end
    if (mem_rd_req) begin
      pend      <= 1'b1;
      dly       <= 2;
      rd_cnt    <= rd_cnt + 1;
      last_addr <= mem_rd_addr;
      idx       <= int'((mem_rd_addr - BASE) >> 2) & 63;
    end
  end

  function automatic logic [31:0] pat(input int i);
    logic [19:0] fr;
    if (i % 5 == 4) return 32'h0;
    fr = (i < 12) ? 20'h00100 + 20'(i * 3) : 20'h80000 + 20'(i);
    if (i == 11) fr = 20'h7FFFF;
    return {fr, 10'd0, 2'(i % 4)};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic xact(input logic [31:0] va, input bit wr, input bit kill,
                      input bit clr, output logic [31:0] a, output bit f,
                      output int nrd);
    int c0, t;
    c0 = rd_cnt;
    t = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = va; req_write = wr; flt_clr = clr;
    do begin
      @(negedge clk);
      flt_clr = 1'b0;
      inval_t = kill && mem_rd_req;
      t++;
    end while (!rsp_valid && t < 100);
    if (t >= 100) chk(1'b0, "R3", "response timeout", 32'(t), 32'd0);
    a = rsp_addr; f = rsp_fault;
    req_valid = 1'b0; inval_t = 1'b0;
    nrd = rd_cnt - c0;
  endtask

  task automatic do_inval();
    @(negedge clk); inval_t = 1'b1;
    @(negedge clk); inval_t = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); flt_clr = 1'b1;
    @(negedge clk); flt_clr = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a, e, pte, pg;
    bit f, ef;
    int n;
    string rq;
    for (int i = 0; i < 64; i++)
      tbl[i] = (i < 16) ? pat(i) : {20'h00200 + 20'(i), 10'd0, 2'b11};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && !mem_rd_req && !flt_valid, "R1", "reset outputs",
        {29'd0, rsp_valid, mem_rd_req, flt_valid}, 32'd0);

    // R2 window edges
    xact(32'h00FF_FFFC, 1'b0, 1'b0, 1'b0, a, f, n);
    chk(f && n == 0, "R2", "below window fault/no read", 32'(n), 32'd0);
    chk(a == ERRA, "R7", "below window redirect", a, ERRA);
    xact(32'h0101_0000, 1'b0, 1'b0, 1'b0, a, f, n);
    chk(f && n == 0, "R2", "window end fault/no read", {31'd0, f}, 32'd1);
    xact(32'h0100_FFFF, 1'b0, 1'b0, 1'b0, a, f, n);
    chk(n == 1 && last_addr == BASE + 60, "R2", "last page reads", last_addr, BASE + 60);

    // sweep all pages, both access kinds
    for (int i = 0; i < 16; i++) begin
      for (int w = 0; w < 2; w++) begin
        logic [31:0] va;
        va  = VST + 32'(i * 4096) + 32'((i * 37 + w * 500) & 12'hFFF);
        pte = tbl[i];
        pg  = {pte[31:12], 12'h000};
        ef  = (pte == 0) || (w == 1 ? !pte[0] : !pte[1]) || pg < WLO || pg > WHI;
        e   = ef ? ERRA : {pte[31:12], va[11:0]};
        if (pte == 0 || (w == 1 ? !pte[0] : !pte[1])) rq = "R5";
        else if (ef) rq = "R6";
        else rq = "R4";
        do_inval();
        xact(va, w[0], 1'b0, 1'b0, a, f, n);
        chk(n == 1, "R3", "one read per miss", 32'(n), 32'd1);
        chk(last_addr == BASE + 32'(i * 4), "R3", "table address", last_addr, BASE + 32'(i * 4));
        chk(f == ef, rq, "fault flag", {31'd0, f}, {31'd0, ef});
        chk(a == e, ef ? "R7" : "R4", "response address", a, e);
        xact(va, w[0], 1'b0, 1'b0, a, f, n);
        chk(n == 0 && a == e, "R9", "cached hit", 32'(n), 32'd0);
      end
    end

    // R2 with a two-region window
    cfg_regions = 12'd2;
    do_inval();
    xact(32'h0101_0010, 1'b0, 1'b0, 1'b0, a, f, n);
    chk(!f && n == 1 && last_addr == BASE + 64, "R2", "second region reads", last_addr, BASE + 64);
    xact(32'h0102_0000, 1'b0, 1'b0, 1'b0, a, f, n);
    chk(f && n == 0, "R2", "end of two regions", 32'(n), 32'd0);

    // R9 round robin
    do_inval();
    for (int p = 1; p <= 5; p++) xact(VST + 32'(p * 4096), 1'b0, 1'b0, 1'b0, a, f, n);
    for (int p = 2; p <= 5; p++) begin
      xact(VST + 32'(p * 4096), 1'b0, 1'b0, 1'b0, a, f, n);
      chk(n == 0, "R9", "newer page kept", 32'(n), 32'd0);
    end
    xact(VST + 32'h1000, 1'b0, 1'b0, 1'b0, a, f, n);
    chk(n == 1, "R9", "oldest page evicted", 32'(n), 32'd1);

    // R10 invalidate makes new contents visible
    do_inval();
    xact(VST + 32'h3000, 1'b0, 1'b0, 1'b0, a, f, n);
    tbl[3] = 32'h1234_5003;
    xact(VST + 32'h3044, 1'b0, 1'b0, 1'b0, a, f, n);
    chk(n == 0 && a == {pat(3)[31:12], 12'h044}, "R10", "stale before inval", a, {pat(3)[31:12], 12'h044});
    do_inval();
    xact(VST + 32'h3044, 1'b0, 1'b0, 1'b0, a, f, n);
    chk(n == 1 && a == 32'h1234_5044, "R10", "fresh after inval", a, 32'h1234_5044);
    tbl[3] = pat(3);

    // R11 invalidate while the read is outstanding
    do_inval();
    xact(VST + 32'h7008, 1'b0, 1'b1, 1'b0, a, f, n);
    e = {pat(7)[31:12], 12'h008};
    chk(n == 1 && !f && a == e, "R11", "killed read still answers", a, e);
    xact(VST + 32'h7008, 1'b0, 1'b0, 1'b0, a, f, n);
    chk(n == 1, "R11", "killed entry not cached", 32'(n), 32'd1);

    // R8 sticky fault record
    do_clr();
    xact(32'h0000_1000, 1'b0, 1'b0, 1'b0, a, f, n);
    xact(32'h0000_2000, 1'b1, 1'b0, 1'b0, a, f, n);
    chk(flt_valid && flt_vaddr == 32'h0000_1000, "R8", "first fault kept", flt_vaddr, 32'h0000_1000);
    do_clr();
    chk(!flt_valid, "R8", "cleared", {31'd0, flt_valid}, 32'd0);
    xact(32'h0000_3000, 1'b0, 1'b0, 1'b0, a, f, n);
    xact(32'h0000_4000, 1'b0, 1'b0, 1'b1, a, f, n);
    chk(flt_valid && flt_vaddr == 32'h0000_4000, "R8", "clear with new fault", flt_vaddr, 32'h0000_4000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule